// File: doc/BRIEF.md
# Dual-Clock Video Row FIFO with Line Start Threshold

This block moves video rows from a pixel clock domain into a link symbol clock domain. Each row is one data word plus an end-of-line flag. It holds 64 rows. Write and read pointers cross between the two domains as Gray codes through two-flop synchronizers, so each side sees only a stable, slightly late view of the other side's pointer.

On the read side a start gate controls latency. A line-start pulse arms the gate and captures a 6-bit threshold. Rows are not presented until the number of rows held reaches that threshold. After that, rows keep flowing until the row that carries the end-of-line flag has been taken. The gate then stays closed until the next line-start pulse. The threshold is normally chosen from the ratio of the pixel clock to the link clock. Its reset value, 32, puts the start point at half depth, which suits two equal clocks.

An overflow flag in the write domain and an underflow flag in the read domain record misuse. Each flag stays set until its own clear input is pulsed.

Top module: `vid_cdc_fifo`

## Requirements
- R1: After reset, rd_valid, wr_full, wr_ovf and rd_udf are 0, and the captured threshold is 32, so a line with no line-start pulse opens at 32 rows.
- R2: Rows leave in the order they were written. Each row keeps its data word and its end-of-line bit, which appear on rd_data and rd_eol.
- R3: After a line start, rd_valid stays 0 while fewer rows than the captured threshold are held. Once that many rows are held, the gate opens and rd_valid is 1.
- R4: Once the gate is open, rows keep being presented even when the fill level drops below the threshold. After a row with rd_eol=1 is taken, rd_valid is 0 even if rows remain, until the next rd_line_start.
- R5: cfg_thresh is sampled only on a cycle with rd_line_start=1. Changes on other cycles have no effect on the current line.
- R6: A captured threshold of 0 opens the gate straight after the line start. An empty FIFO still gives rd_valid=0.
- R7: rd_en while the gate is closed removes no row and does not set rd_udf.
- R8: A write while 64 rows are held is dropped. It sets wr_ovf, which stays 1 until wr_ovf_clr. wr_full is 1 while 64 rows are held.
- R9: rd_en while the gate is open and the FIFO is empty sets rd_udf, which stays 1 until rd_udf_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Pixel clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_en | input | 1 | Write one row |
| wr_data | input | DATA_W | Row data |
| wr_eol | input | 1 | Row is the last of its line |
| wr_ovf_clr | input | 1 | Clear the overflow flag |
| wr_full | output | 1 | 64 rows held (write-domain view) |
| wr_ovf | output | 1 | Sticky overflow flag |
| rd_clk | input | 1 | Link symbol clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_line_start | input | 1 | Arm the gate and capture cfg_thresh |
| cfg_thresh | input | ADDR_W | Start threshold in rows (0 to 63) |
| rd_en | input | 1 | Take the presented row |
| rd_valid | output | 1 | A row is presented |
| rd_data | output | DATA_W | Presented row data |
| rd_eol | output | 1 | Presented row ends its line |
| rd_udf_clr | input | 1 | Clear the underflow flag |
| rd_udf | output | 1 | Sticky underflow flag |

## Verification
A wrong read-side fill count or a bad pointer conversion shows up first at the gate. rd_valid rises one row early or late against the threshold, and this is visible within a few link clocks of the deciding write. A gate state that fails to close shows up on the cycle right after the end-of-line row is taken, when rd_valid stays 1 while the next line's rows are waiting. A corrupted write pointer shows up as wrong rd_data order or as wr_full at the wrong count. A flag that is not sticky is lost on the cycle after the event.

// File: rtl/vfifo_pkg.sv
package vfifo_pkg;
  typedef enum logic [1:0] {GATE_IDLE, GATE_WAIT, GATE_RUN} gate_state_e;

  function automatic logic [15:0] bin2gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] gray2bin(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [15:0] ptr_fill(input logic [15:0] head, input logic [15:0] tail);
    return head - tail;
  endfunction
endpackage

// File: rtl/vfifo_sync.sv
module vfifo_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/vfifo_wr_ctl.sv
module vfifo_wr_ctl
  import vfifo_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              ovf_clr,
  input  logic [PTR_W-1:0]  rd_gray_s,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PTR_W-1:0]  wr_gray,
  output logic              wr_push,
  output logic              full,
  output logic              ovf
);
  logic [PTR_W-1:0] wr_bin, rd_bin_s, wr_bin_nx;

  assign rd_bin_s  = PTR_W'(gray2bin(16'(rd_gray_s)));
  assign full      = (wr_bin[ADDR_W] != rd_bin_s[ADDR_W]) &&
                     (wr_bin[ADDR_W-1:0] == rd_bin_s[ADDR_W-1:0]);
  assign wr_push   = wr_en && !full;
  assign wr_bin_nx = wr_bin + PTR_W'(1);
  assign wr_addr   = wr_bin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      ovf     <= 1'b0;
    end else begin
      if (wr_push) begin
        wr_bin  <= wr_bin_nx;
        wr_gray <= PTR_W'(bin2gray(16'(wr_bin_nx)));
      end
      if (wr_en && full) ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/vfifo_rd_gate.sv
module vfifo_rd_gate
  import vfifo_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [ADDR_W-1:0] cfg_thresh,
  input  logic              rd_en,
  input  logic              head_eol,
  input  logic              udf_clr,
  input  logic [PTR_W-1:0]  wr_gray_s,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [PTR_W-1:0]  rd_gray,
  output logic [PTR_W-1:0]  fill,
  output logic [ADDR_W-1:0] act_thr,
  output logic              gate_run,
  output logic              rd_pop,
  output logic              rd_valid,
  output logic              udf
);
  gate_state_e      state;
  logic [PTR_W-1:0] rd_bin, wr_bin_s, rd_bin_nx;
  logic             empty;

  assign wr_bin_s  = PTR_W'(gray2bin(16'(wr_gray_s)));
  assign fill      = PTR_W'(ptr_fill(16'(wr_bin_s), 16'(rd_bin)));
  assign empty     = (fill == '0);
  assign gate_run  = (state == GATE_RUN);
  assign rd_valid  = gate_run && !empty;
  assign rd_pop    = rd_en && rd_valid;
  assign rd_bin_nx = rd_bin + PTR_W'(1);
  assign rd_addr   = rd_bin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= GATE_WAIT;
      act_thr <= ADDR_W'(DEPTH / 2);
      rd_bin  <= '0;
      rd_gray <= '0;
      udf     <= 1'b0;
    end else begin
      if (rd_pop) begin
        rd_bin  <= rd_bin_nx;
        rd_gray <= PTR_W'(bin2gray(16'(rd_bin_nx)));
      end
      if (line_start) begin
        state   <= GATE_WAIT;
        act_thr <= cfg_thresh;
      end else begin
        case (state)
          GATE_WAIT: if (fill >= PTR_W'(act_thr)) state <= GATE_RUN;
          GATE_RUN:  if (rd_pop && head_eol)      state <= GATE_IDLE;
          default:   state <= state;
        endcase
      end
      if (rd_en && gate_run && empty) udf <= 1'b1;
      else if (udf_clr)               udf <= 1'b0;
    end
  end
endmodule

// File: rtl/vid_cdc_fifo.sv
module vid_cdc_fifo #(
  parameter int DATA_W      = 24,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eol,
  input  logic              wr_ovf_clr,
  output logic              wr_full,
  output logic              wr_ovf,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_line_start,
  input  logic [ADDR_W-1:0] cfg_thresh,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_eol,
  input  logic              rd_udf_clr,
  output logic              rd_udf
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W:0]   mem [DEPTH];
  logic [ADDR_W-1:0] wr_addr, rd_addr, act_thr;
  logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_s, rd_gray_s, rd_fill;
  logic              wr_push, rd_pop, gate_run, head_eol;
  logic [DATA_W:0]   head;

  vfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) w2r_i (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s));

  vfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) r2w_i (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s));

  vfifo_wr_ctl #(.ADDR_W(ADDR_W)) wctl_i (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .ovf_clr(wr_ovf_clr),
    .rd_gray_s(rd_gray_s), .wr_addr(wr_addr), .wr_gray(wr_gray),
    .wr_push(wr_push), .full(wr_full), .ovf(wr_ovf));

  vfifo_rd_gate #(.ADDR_W(ADDR_W)) gate_i (
    .clk(rd_clk), .rst_n(rd_rst_n), .line_start(rd_line_start),
    .cfg_thresh(cfg_thresh), .rd_en(rd_en), .head_eol(head_eol),
    .udf_clr(rd_udf_clr), .wr_gray_s(wr_gray_s), .rd_addr(rd_addr),
    .rd_gray(rd_gray), .fill(rd_fill), .act_thr(act_thr),
    .gate_run(gate_run), .rd_pop(rd_pop), .rd_valid(rd_valid), .udf(rd_udf));

  always_ff @(posedge wr_clk) begin
    if (wr_push) mem[wr_addr] <= {wr_eol, wr_data};
  end

  assign head     = mem[rd_addr];
  assign head_eol = head[DATA_W];
  assign rd_eol   = head_eol;
  assign rd_data  = head[DATA_W-1:0];
endmodule

// File: rtl/vfifo_chk.sv
module vfifo_chk #(
  parameter int ADDR_W = 6,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              wr_en,
  input logic              wr_full,
  input logic              wr_ovf,
  input logic              wr_ovf_clr,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              rd_line_start,
  input logic              rd_udf,
  input logic              rd_udf_clr,
  input logic              rd_pop,
  input logic              gate_run,
  input logic              head_eol,
  input logic [PTR_W-1:0]  rd_fill,
  input logic [ADDR_W-1:0] act_thr
);
  // R2
  fill_bound_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_fill <= PTR_W'(DEPTH));

  // R3
  gate_open_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $rose(gate_run) |-> (rd_fill >= PTR_W'(act_thr)));

  // R4
  eol_close_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_pop && head_eol && !rd_line_start) |=> !gate_run);

  // R5
  thr_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_line_start |=> $stable(act_thr));

  // R7
  closed_no_pop_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !gate_run |-> !rd_pop);

  // R8
  ovf_set_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_full) |=> wr_ovf);

  // R8
  ovf_sticky_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_ovf && !wr_ovf_clr) |=> wr_ovf);

  // R9
  udf_sticky_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_udf && !rd_udf_clr) |=> rd_udf);
endmodule

bind vid_cdc_fifo vfifo_chk #(.ADDR_W(ADDR_W)) chk_i (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_full(wr_full),
  .wr_ovf(wr_ovf), .wr_ovf_clr(wr_ovf_clr), .rd_clk(rd_clk),
  .rd_rst_n(rd_rst_n), .rd_line_start(rd_line_start), .rd_udf(rd_udf),
  .rd_udf_clr(rd_udf_clr), .rd_pop(rd_pop), .gate_run(gate_run),
  .head_eol(head_eol), .rd_fill(rd_fill), .act_thr(act_thr));

// File: tb/vid_cdc_fifo_tb_top.sv
module vid_cdc_fifo_tb_top;
  localparam int DATA_W = 24;
  localparam int ADDR_W = 6;
  localparam int VEC_N  = 8;
  localparam int V_TH  [VEC_N] = '{32, 32, 1, 63, 63, 5, 10, 0};
  localparam int V_ROWS[VEC_N] = '{31, 32, 1, 62, 63, 10, 5, 0};
  localparam int V_EXP [VEC_N] = '{0,  1,  1, 0,  1,  1,  0,  0};

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_en = 0, wr_eol = 0, wr_ovf_clr = 0, wr_full, wr_ovf;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic rd_line_start = 0, rd_en = 0, rd_valid, rd_eol, rd_udf_clr = 0, rd_udf;
  logic [ADDR_W-1:0] cfg_thresh = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 wr_clk = ~wr_clk;
  always #5 rd_clk = ~rd_clk;

  vid_cdc_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_eol(wr_eol), .wr_ovf_clr(wr_ovf_clr), .wr_full(wr_full), .wr_ovf(wr_ovf),
    .rd_clk(rd_clk), .rd_rst_n(rst_n), .rd_line_start(rd_line_start),
    .cfg_thresh(cfg_thresh), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_eol(rd_eol), .rd_udf_clr(rd_udf_clr), .rd_udf(rd_udf));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    wr_en = 0; rd_en = 0; rd_line_start = 0; wr_ovf_clr = 0; rd_udf_clr = 0;
    repeat (3) @(negedge rd_clk);
    rst_n = 1;
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic push(input int d, input bit eol);
    @(negedge wr_clk);
    wr_en = 1; wr_data = DATA_W'(d); wr_eol = eol;
    @(negedge wr_clk);
    wr_en = 0; wr_eol = 0;
  endtask

  task automatic line_start(input int th);
    @(negedge rd_clk);
    cfg_thresh = ADDR_W'(th); rd_line_start = 1;
    @(negedge rd_clk);
    rd_line_start = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic pop_check(input string tag, input int d, input bit eol);
    @(negedge rd_clk);
    check({tag, " valid"}, int'(rd_valid), 1);
    check({tag, " data"}, int'(rd_data), d);
    check({tag, " eol"}, int'(rd_eol), int'(eol));
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
  endtask

  task automatic rd_pulse();
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R3 table: threshold, rows written, expected gate state
    for (int v = 0; v < VEC_N; v++) begin
      do_reset();
      line_start(V_TH[v]);
      for (int k = 0; k < V_ROWS[v]; k++) push(v * 100 + k, k == V_ROWS[v] - 1);
      settle();
      check($sformatf("R3 vec%0d rd_valid", v), int'(rd_valid), V_EXP[v]);
    end

    // R1 reset state and default threshold of 32
    do_reset();
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 wr_full", int'(wr_full), 0);
    check("R1 wr_ovf", int'(wr_ovf), 0);
    check("R1 rd_udf", int'(rd_udf), 0);
    for (int k = 0; k < 31; k++) push(k, 0);
    settle();
    check("R1 31 rows below default", int'(rd_valid), 0);
    push(31, 1);
    push(999, 0);
    settle();
    check("R1 32 rows open", int'(rd_valid), 1);
    // R2 order and R4 continuing below threshold
    for (int k = 0; k < 32; k++) pop_check("R2 R4 line row", k, k == 31);
    check("R4 closed after eol", int'(rd_valid), 0);
    settle();
    check("R4 stays closed with row held", int'(rd_valid), 0);
    // R7 read while closed ignored
    rd_pulse();
    settle();
    check("R7 no underflow", int'(rd_udf), 0);
    line_start(1);
    settle();
    pop_check("R7 row kept", 999, 0);

    // R5 mid-line threshold change ignored
    do_reset();
    line_start(10);
    for (int k = 0; k < 5; k++) push(k, 0);
    @(negedge rd_clk); cfg_thresh = 2;
    settle();
    check("R5 change ignored", int'(rd_valid), 0);
    for (int k = 5; k < 10; k++) push(k, k == 9);
    settle();
    check("R5 opens at captured 10", int'(rd_valid), 1);

    // R6 threshold zero and R9 underflow
    do_reset();
    line_start(0);
    settle();
    check("R6 empty not valid", int'(rd_valid), 0);
    rd_pulse();
    settle();
    check("R9 underflow set", int'(rd_udf), 1);
    settle();
    check("R9 underflow sticky", int'(rd_udf), 1);
    @(negedge rd_clk); rd_udf_clr = 1;
    @(negedge rd_clk); rd_udf_clr = 0;
    check("R9 underflow cleared", int'(rd_udf), 0);
    push(77, 1);
    settle();
    check("R6 one row valid", int'(rd_valid), 1);

    // R8 overflow
    do_reset();
    for (int k = 0; k < 64; k++) push(k, k == 63);
    check("R8 full at 64", int'(wr_full), 1);
    check("R8 no ovf yet", int'(wr_ovf), 0);
    push(500, 0);
    check("R8 ovf set", int'(wr_ovf), 1);
    settle();
    for (int k = 0; k < 64; k++) pop_check("R8 R2 kept rows", k, k == 63);
    settle();
    check("R8 dropped row absent", int'(rd_valid), 0);
    check("R8 ovf sticky", int'(wr_ovf), 1);
    check("R8 not full after drain", int'(wr_full), 0);
    @(negedge wr_clk); wr_ovf_clr = 1;
    @(negedge wr_clk); wr_ovf_clr = 0;
    check("R8 ovf cleared", int'(wr_ovf), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule